// File: doc/BRIEF.md
# Configurable Product-Term Logic Cell

This block is one programmable logic cell. Eighteen logic inputs feed an AND array whose literal selection comes from a configuration vector. Twenty general product terms feed four output paths. Each output takes either a wide sum, which is an OR over any chosen subset of the twenty terms followed by an optional XOR with one dedicated term, or a short sum, which is a fixed group of four terms that skips the allocation mask. Each output can be driven straight from that logic or through a register.

Three further product terms serve as controls. The first can replace the global clock as the capture event for the registers. The second can clear the registers. The third can drive an output-enable line toward the pad stage.

The configuration vector is a static input port. The cell samples it on every clock edge while the active-low reset is held and freezes it when reset is released. Global routing, pad buffers, non-volatile storage and the programming protocol lie outside the block.

Top module: `pt_cell`

## Requirements
- R1: Reset is synchronous and active-low. At every rising clock edge with `rst_n` low, all four output registers clear to 0. At every such edge the configuration register also loads `cfg_i`, so the value present at the last reset edge is the one that takes effect.
- R2: After reset is released, changes on `cfg_i` have no effect on any output.
- R3: Term t (0..22) uses two select bits per input i, at `cfg_i[36*t + 2*i +: 2]`. The codes are: 01 uses the input true, 10 uses it complemented, 00 ignores it, and 11 forces the term to 0. A term is the AND of its used literals.
- R4: A term whose 36 select bits are all 00 is unused and evaluates to 0.
- R5: Output k has a 23-bit field at `cfg_i[828 + 23*k +: 23]`. Bits 19..0 of that field are the OR allocation mask over terms 19..0. With bits 20 and 21 clear, the wide sum is the OR of the terms selected by the mask.
- R6: Field bit 20 enables the XOR stage. The wide sum then becomes the masked OR XOR term 16+k.
- R7: Field bit 21 selects the short path. The logic value of output k is then the OR of terms 4k..4k+3, and the mask and the XOR stage are ignored.
- R8: With field bit 22 clear, `dout[k]` follows the logic value combinationally, in the same cycle as the input change.
- R9: With field bit 22 set, `dout[k]` shows a register. Under the global clock mode (`cfg_i[920]` = 0) the register captures the logic value at every rising edge.
- R10: With `cfg_i[920]` = 1, the registers capture only at a rising edge where term 20 is 1 and was 0 at the previous edge. At all other edges they hold their value.
- R11: With `cfg_i[921]` = 1, a rising edge at which term 21 is 1 clears every output register. This clear takes priority over a capture.
- R12: `oe_o` equals term 22 when `cfg_i[922]` = 1, and is 1 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Global clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset; also opens configuration load |
| cfg_i | input | 923 | Static configuration vector, sampled while in reset |
| din | input | 18 | Logic inputs to the AND array |
| dout | output | 4 | Cell outputs, combinational or registered per bit |
| oe_o | output | 1 | Output enable toward the pad stage |

## Verification
Combinational results (R3 to R8, R12) are due in the cycle of the input change. The bench drives inputs on the falling edge and samples one nanosecond later, before any rising edge can intervene. Registered results (R1, R9 to R11) are due one rising edge after the stimulus, so the bench drives at a falling edge, waits for one rising edge and samples at the next falling edge. For R9 it also samples before that edge to show that the old value still holds. Configuration takes effect from the falling edge that ends reset, because it is loaded at the last reset edge.

// File: rtl/pt_cell_pkg.sv
package pt_cell_pkg;

    // Literal select code, two bits per input per product term
    typedef enum logic [1:0] {
        LIT_DC   = 2'b00,
        LIT_POS  = 2'b01,
        LIT_NEG  = 2'b10,
        LIT_NONE = 2'b11
    } lit_e;

    // Control terms, counted after the general terms
    localparam int CTL_CLK = 0;
    localparam int CTL_RST = 1;
    localparam int CTL_OE  = 2;
    localparam int N_CTL   = 3;

    // Per-output field bits, counted after the OR mask
    localparam int OF_XOR  = 0;
    localparam int OF_BYP  = 1;
    localparam int OF_REG  = 2;
    localparam int N_OFLAG = 3;

    // Global configuration bits
    localparam int GF_CLK_SEL = 0;
    localparam int GF_RST_EN  = 1;
    localparam int GF_OE_EN   = 2;
    localparam int N_GFLAG    = 3;

endpackage

// File: rtl/pt_term_array.sv
module pt_term_array
    import pt_cell_pkg::*;
#(
    parameter int N_IN   = 18,
    parameter int N_TERM = 23
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [N_IN-1:0]            din,
    input  logic [2*N_IN*N_TERM-1:0]   lit_cfg,
    output logic [N_TERM-1:0]          terms
);
    localparam int TW = 2 * N_IN;

    function automatic logic [TW-1:0] even_bits();
        logic [TW-1:0] m;
        m = '0;
        for (int i = 0; i < N_IN; i++) m[2*i] = 1'b1;
        return m;
    endfunction

    localparam logic [TW-1:0] EVEN = even_bits();

    for (genvar t = 0; t < N_TERM; t++) begin : g_term
        logic [TW-1:0] sel;
        logic          hit;
        logic          used;

        assign sel = lit_cfg[t*TW +: TW];

        always_comb begin
            hit  = 1'b1;
            used = 1'b0;
            for (int i = 0; i < N_IN; i++) begin
                case (lit_e'(sel[2*i +: 2]))
                    LIT_POS:  begin used = 1'b1; hit = hit & din[i];  end
                    LIT_NEG:  begin used = 1'b1; hit = hit & ~din[i]; end
                    LIT_NONE: begin used = 1'b1; hit = 1'b0;          end
                    default:  ;
                endcase
            end
            terms[t] = hit & used;
        end

        // R4: a term with no literal selected never contributes
        a_r4_unused_zero: assert property (@(posedge clk) disable iff (!rst_n)
            (sel == '0) |-> !terms[t]);

        // R3: any blocked literal forces the term low
        a_r3_blocked_zero: assert property (@(posedge clk) disable iff (!rst_n)
            (((sel & (sel >> 1)) & EVEN) != '0) |-> !terms[t]);
    end

endmodule

// File: rtl/pt_out_sum.sv
module pt_out_sum #(
    parameter int N_PT    = 20,
    parameter int BYP_W   = 4,
    parameter int GRP_IDX = 0,
    parameter int XOR_IDX = 16
) (
    input  logic [N_PT-1:0] terms,
    input  logic [N_PT-1:0] or_mask,
    input  logic            xor_en,
    input  logic            byp_sel,
    output logic            sum_o
);
    logic wide_or;
    logic wide_sum;
    logic short_sum;

    always_comb begin
        wide_or   = |(terms & or_mask);
        wide_sum  = wide_or ^ (xor_en & terms[XOR_IDX]);
        short_sum = |terms[GRP_IDX*BYP_W +: BYP_W];
        sum_o     = byp_sel ? short_sum : wide_sum;
    end

endmodule

// File: rtl/pt_cell.sv
module pt_cell
    import pt_cell_pkg::*;
#(
    parameter int N_IN  = 18,
    parameter int N_PT  = 20,
    parameter int N_OUT = 4,
    parameter int BYP_W = 4,
    localparam int N_TERM = N_PT + N_CTL,
    localparam int LIT_W  = 2 * N_IN * N_TERM,
    localparam int OUT_W  = N_PT + N_OFLAG,
    localparam int GLB_LO = LIT_W + N_OUT * OUT_W,
    localparam int CFG_W  = GLB_LO + N_GFLAG
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CFG_W-1:0]  cfg_i,
    input  logic [N_IN-1:0]   din,
    output logic [N_OUT-1:0]  dout,
    output logic              oe_o
);
    typedef struct packed {
        logic [CFG_W-1:0] cfg;
        logic [N_OUT-1:0] q;
        logic             ptclk;
    } state_t;

    state_t st_d, st_q;

    logic [N_TERM-1:0] terms;
    logic [N_OUT-1:0]  logic_val;
    logic [N_OUT-1:0]  reg_sel;
    logic              clk_sel, rst_en, oe_en;
    logic              cap_w, ptrst_w;

    pt_term_array #(
        .N_IN   (N_IN),
        .N_TERM (N_TERM)
    ) u_terms (
        .clk     (clk),
        .rst_n   (rst_n),
        .din     (din),
        .lit_cfg (st_q.cfg[LIT_W-1:0]),
        .terms   (terms)
    );

    for (genvar k = 0; k < N_OUT; k++) begin : g_out
        localparam int BASE = LIT_W + k * OUT_W;

        pt_out_sum #(
            .N_PT    (N_PT),
            .BYP_W   (BYP_W),
            .GRP_IDX (k),
            .XOR_IDX (N_PT - N_OUT + k)
        ) u_sum (
            .terms   (terms[N_PT-1:0]),
            .or_mask (st_q.cfg[BASE +: N_PT]),
            .xor_en  (st_q.cfg[BASE + N_PT + OF_XOR]),
            .byp_sel (st_q.cfg[BASE + N_PT + OF_BYP]),
            .sum_o   (logic_val[k])
        );

        assign reg_sel[k] = st_q.cfg[BASE + N_PT + OF_REG];
        assign dout[k]    = reg_sel[k] ? st_q.q[k] : logic_val[k];
    end

    assign clk_sel = st_q.cfg[GLB_LO + GF_CLK_SEL];
    assign rst_en  = st_q.cfg[GLB_LO + GF_RST_EN];
    assign oe_en   = st_q.cfg[GLB_LO + GF_OE_EN];

    assign cap_w   = clk_sel ? (terms[N_PT + CTL_CLK] & ~st_q.ptclk) : 1'b1;
    assign ptrst_w = rst_en & terms[N_PT + CTL_RST];
    assign oe_o    = oe_en ? terms[N_PT + CTL_OE] : 1'b1;

    always_comb begin
        st_d = st_q;
        if (!rst_n) begin
            st_d.cfg   = cfg_i;
            st_d.q     = '0;
            st_d.ptclk = 1'b0;
        end else begin
            st_d.ptclk = terms[N_PT + CTL_CLK];
            if (ptrst_w) begin
                st_d.q = '0;
            end else if (cap_w) begin
                for (int k = 0; k < N_OUT; k++) begin
                    if (reg_sel[k]) st_d.q[k] = logic_val[k];
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    // R1: the cycle after reset ends starts with cleared registers
    a_r1_reset_clears: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (st_q.q == '0));

    // R2: configuration is frozen once reset is released
    a_r2_cfg_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> $stable(st_q.cfg));

    // R10: with no capture event and no clear, registers hold
    a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!cap_w && !ptrst_w) |=> $stable(st_q.q));

    // R11: a product-term clear empties every register
    a_r11_ptrst_clear: assert property (@(posedge clk) disable iff (!rst_n)
        ptrst_w |=> (st_q.q == '0));

endmodule

// File: tb/sim_pt_cell.sv
`timescale 1ns/1ps
module sim_pt_cell;
    localparam int CW   = 923;
    localparam int OBAS = 828;
    localparam int OW   = 23;
    localparam int GBAS = 920;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [CW-1:0] cfg_i = '0;
    logic [17:0]   din = '0;
    logic [3:0]    dout;
    logic          oe_o;

    logic [CW-1:0] cfg;
    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #4 clk = ~clk;

    pt_cell u0 (
        .clk   (clk),
        .rst_n (rst_n),
        .cfg_i (cfg_i),
        .din   (din),
        .dout  (dout),
        .oe_o  (oe_o)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    // R3 layout: term t, input i at 36*t + 2*i
    task automatic lit(input int t, input int i, input logic [1:0] code);
        cfg[36*t + 2*i +: 2] = code;
    endtask
    task automatic mask(input int k, input int t);
        cfg[OBAS + OW*k + t] = 1'b1;
    endtask
    task automatic oflag(input int k, input int b);
        cfg[OBAS + OW*k + 20 + b] = 1'b1;
    endtask
    task automatic gflag(input int b);
        cfg[GBAS + b] = 1'b1;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        cfg_i = cfg;
        din   = '0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic comb_chk(input string req, input logic [17:0] v, input int k, input logic exp);
        @(negedge clk);
        din = v;
        #1;
        chk(req, dout[k], exp);
    endtask

    task automatic reg_step(input string req, input logic [17:0] v, input int k, input logic exp);
        @(negedge clk);
        din = v;
        @(posedge clk);
        @(negedge clk);
        chk(req, dout[k], exp);
    endtask

    task automatic t_reset();
        cfg = '0;
        lit(0, 0, 2'b01); mask(0, 0); oflag(0, 2);
        @(negedge clk);
        rst_n = 1'b0; cfg_i = cfg; din = '1;
        repeat (2) @(posedge clk);
        @(negedge clk);
        chk("R1 regs clear in reset", dout, 4'b0000);
        rst_n = 1'b1;
        @(posedge clk);
        @(negedge clk);
        chk("R1 loaded cfg active", dout[0], 1'b1);
    endtask

    task automatic t_frozen();
        cfg = '0;
        lit(0, 0, 2'b01); mask(0, 0);
        do_reset();
        cfg_i = '0;
        comb_chk("R2 cfg change ignored", 18'h00001, 0, 1'b1);
        repeat (3) @(posedge clk);
        comb_chk("R2 cfg still frozen", 18'h00000, 0, 1'b0);
    endtask

    task automatic t_terms();
        cfg = '0;
        lit(0, 0, 2'b01); lit(0, 1, 2'b10);
        lit(1, 5, 2'b01); lit(1, 17, 2'b01);
        lit(3, 2, 2'b11); lit(3, 3, 2'b01);
        mask(0, 0); mask(0, 1); mask(0, 2); mask(0, 3);
        do_reset();
        comb_chk("R4 unused term is zero", 18'h00000, 0, 1'b0);
        comb_chk("R3 true and complement", 18'h00001, 0, 1'b1);
        comb_chk("R3 complement blocks", 18'h00003, 0, 1'b0);
        comb_chk("R5 second masked term", 18'h20020, 0, 1'b1);
        comb_chk("R3 code 11 forces zero", 18'h0001C, 0, 1'b0);
        comb_chk("R8 other outputs quiet", 18'h00001, 1, 1'b0);
    endtask

    task automatic t_xor();
        cfg = '0;
        lit(5, 7, 2'b01); lit(17, 6, 2'b01);
        mask(1, 5); oflag(1, 0);
        do_reset();
        comb_chk("R6 xor 0^0", 18'h00000, 1, 1'b0);
        comb_chk("R6 xor 1^0", 18'h00080, 1, 1'b1);
        comb_chk("R6 xor 0^1", 18'h00040, 1, 1'b1);
        comb_chk("R6 xor 1^1", 18'h000C0, 1, 1'b0);
    endtask

    task automatic t_bypass();
        cfg = '0;
        lit(0, 0, 2'b01); lit(8, 8, 2'b01); lit(9, 9, 2'b01);
        mask(2, 0); oflag(2, 1);
        do_reset();
        comb_chk("R7 mask ignored", 18'h00001, 2, 1'b0);
        comb_chk("R7 group term 9", 18'h00200, 2, 1'b1);
        comb_chk("R7 group term 8", 18'h00100, 2, 1'b1);
    endtask

    task automatic t_reg();
        cfg = '0;
        lit(12, 12, 2'b01); mask(3, 12); oflag(3, 2);
        do_reset();
        @(negedge clk);
        din = 18'h01000;
        #1;
        chk("R9 holds before edge", dout[3], 1'b0);
        @(posedge clk);
        @(negedge clk);
        chk("R9 captured at edge", dout[3], 1'b1);
        din = 18'h00000;
        #1;
        chk("R9 old value kept", dout[3], 1'b1);
        @(posedge clk);
        @(negedge clk);
        chk("R9 captured zero", dout[3], 1'b0);
    endtask

    task automatic t_ptclk();
        cfg = '0;
        lit(0, 0, 2'b01); mask(0, 0); oflag(0, 2);
        lit(20, 10, 2'b01); gflag(0);
        do_reset();
        reg_step("R10 no edge no capture", 18'h00001, 0, 1'b0);
        reg_step("R10 rising term captures", 18'h00401, 0, 1'b1);
        reg_step("R10 level high holds", 18'h00400, 0, 1'b1);
        reg_step("R10 falling term holds", 18'h00000, 0, 1'b1);
        reg_step("R10 second rise captures", 18'h00400, 0, 1'b0);
    endtask

    task automatic t_ptrst();
        cfg = '0;
        lit(0, 0, 2'b01); mask(0, 0); oflag(0, 2);
        lit(21, 11, 2'b01); gflag(1);
        do_reset();
        reg_step("R11 normal capture", 18'h00001, 0, 1'b1);
        reg_step("R11 clear beats capture", 18'h00801, 0, 1'b0);
        reg_step("R11 capture resumes", 18'h00001, 0, 1'b1);
    endtask

    task automatic t_oe();
        cfg = '0;
        lit(22, 13, 2'b01);
        do_reset();
        @(negedge clk); din = 18'h00000; #1;
        chk("R12 oe forced high", oe_o, 1'b1);
        gflag(2);
        do_reset();
        @(negedge clk); din = 18'h00000; #1;
        chk("R12 oe term low", oe_o, 1'b0);
        @(negedge clk); din = 18'h02000; #1;
        chk("R12 oe term high", oe_o, 1'b1);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        t_reset();
        t_frozen();
        t_terms();
        t_xor();
        t_bypass();
        t_reg();
        t_ptclk();
        t_ptrst();
        t_oe();
        finish_run();
    end

endmodule